// File: doc/BRIEF.md
# DTMF Steering Qualifier and Output Latch

This block sits behind a dual-tone classifier. It receives the classifier's early-steering flag, which is high while a recognisable tone pair is present, together with that pair's 4-bit key code. The block decides when a tone pair has lasted long enough to count as a digit, and when the following silence has lasted long enough to end it. Two programmable guard timers make these decisions. They count ticks of a 1 ms timebase derived from the system clock. One timer qualifies tone presence and the other qualifies tone absence. Together they give hysteresis: bursts that are too short are rejected, and brief dropouts inside a valid tone are ignored.

When the present guard expires, the key code is captured in an output latch. After a fixed settling delay, the delayed-steering strobe rises, so that the data is already stable when the strobe arrives. The strobe stays high until early steering has been low for the full absent guard. Only then can a new digit be registered. A 4-bit bus presents the latched code while the output enable is high and floats while it is low.

The two guard times are loaded through a small write port. The present and absent values can be set independently. There is no stream interface and no back-pressure. Every input is sampled on every clock edge and must already be synchronous to the clock.

Top module: `dtmf_steer`

## Requirements
- R1: With a present guard of Gp ticks and TICK_CYC clocks per tick, a code is registered only when early steering is sampled high on Gp*TICK_CYC+1 consecutive clock edges. A shorter burst leaves the latch and the strobe unchanged.
- R2: The latch keeps the code of the last registered pair. A code change while the strobe is high is not captured.
- R3: The strobe rises SETTLE_CYC clock edges after the edge that updates the latch. The new code is already visible on the bus while the strobe is still low.
- R4: With an absent guard of Ga ticks, the strobe falls when early steering is sampled low on Ga*TICK_CYC+1 consecutive edges. A shorter dropout leaves the strobe high and does not cause a second registration.
- R5: A write with cfg_sel_i=0 loads the present guard and a write with cfg_sel_i=1 loads the absent guard. The two guards are independent, so the present guard may be shorter or longer than the absent guard.
- R6: When oe_i is high, q_o carries the latched code. When oe_i is low, q_o is high impedance.
- R7: After reset the strobe is low, the latch holds 0, and the guards take the values PRESENT_DEF and ABSENT_DEF.
- R8: A new pair can be registered only after the strobe has returned low. Qualification of a new pair starts from zero at that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| est_i | input | 1 | Early-steering flag from the tone classifier |
| code_i | input | 4 | Key code of the tone pair currently detected |
| cfg_wr_i | input | 1 | Guard register write strobe |
| cfg_sel_i | input | 1 | Write target: 0 selects the present guard, 1 selects the absent guard |
| cfg_data_i | input | 16 | Guard value, in ticks |
| oe_i | input | 1 | Output bus enable |
| q_o | output | 4 | Latched key code, high impedance when disabled |
| std_o | output | 1 | Delayed-steering strobe |

## Verification
The assertions assume that est_i and code_i are synchronous, single-clock signals. They also assume that the guard values stay non-zero and are not rewritten while a qualification is in progress. The bench drives every input on the falling edge. It writes guards only while early steering is low and the strobe is idle, and it sweeps present and absent guards from 1 to 3 ticks using a 3-clock tick. Every guard expiry therefore lands on an edge that the bench can compute exactly.

// File: rtl/dtmf_steer_pkg.sv
package dtmf_steer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_HELD   = 2'd2
  } steer_st_t;
endpackage

// File: rtl/dtmf_guard_timer.sv
// Restartable tick prescaler plus tick counter; expires after limit ticks of
// uninterrupted run.
module dtmf_guard_timer #(
  parameter int TICK_CYC = 100000,
  parameter int GUARD_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [GUARD_W-1:0] limit,
  output logic               expired
);
  localparam int PRE_W = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_CYC - 1);

  logic [PRE_W-1:0]   pre_q;
  logic [GUARD_W-1:0] cnt_q;
  logic               tick;

  assign tick = run && (pre_q == PRE_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (!run || tick) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run) begin
      cnt_q <= '0;
    end else if (tick && (cnt_q != '1)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired = run && (cnt_q >= limit);
endmodule

// File: rtl/dtmf_guard_regs.sv
module dtmf_guard_regs #(
  parameter int GUARD_W     = 16,
  parameter int PRESENT_DEF = 40,
  parameter int ABSENT_DEF  = 40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic               sel,
  input  logic [GUARD_W-1:0] wdata,
  output logic [GUARD_W-1:0] present_q,
  output logic [GUARD_W-1:0] absent_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      present_q <= GUARD_W'(PRESENT_DEF);
      absent_q  <= GUARD_W'(ABSENT_DEF);
    end else if (wr) begin
      if (sel) absent_q  <= wdata;
      else     present_q <= wdata;
    end
  end
endmodule

// File: rtl/dtmf_steer.sv
module dtmf_steer
  import dtmf_steer_pkg::*;
#(
  parameter int TICK_CYC    = 100000,
  parameter int GUARD_W     = 16,
  parameter int CODE_W      = 4,
  parameter int SETTLE_CYC  = 2,
  parameter int PRESENT_DEF = 40,
  parameter int ABSENT_DEF  = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              est_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              cfg_wr_i,
  input  logic              cfg_sel_i,
  input  logic [GUARD_W-1:0] cfg_data_i,
  input  logic              oe_i,
  output logic [CODE_W-1:0] q_o,
  output logic              std_o
);
  localparam int SET_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [SET_W-1:0] SET_LAST = SET_W'((SETTLE_CYC > 0) ? SETTLE_CYC - 1 : 0);

  steer_st_t          st_q;
  logic [SET_W-1:0]   set_q;
  logic [CODE_W-1:0]  latch_q;
  logic [GUARD_W-1:0] g_present, g_absent;
  logic               run_present, run_absent;
  logic               present_done, absent_done;

  dtmf_guard_regs #(
    .GUARD_W(GUARD_W), .PRESENT_DEF(PRESENT_DEF), .ABSENT_DEF(ABSENT_DEF)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr_i), .sel(cfg_sel_i),
    .wdata(cfg_data_i), .present_q(g_present), .absent_q(g_absent)
  );

  assign run_present = est_i && (st_q == ST_IDLE);
  assign run_absent  = !est_i && (st_q == ST_HELD);

  dtmf_guard_timer #(.TICK_CYC(TICK_CYC), .GUARD_W(GUARD_W)) u_present (
    .clk(clk), .rst_n(rst_n), .run(run_present), .limit(g_present),
    .expired(present_done)
  );

  dtmf_guard_timer #(.TICK_CYC(TICK_CYC), .GUARD_W(GUARD_W)) u_absent (
    .clk(clk), .rst_n(rst_n), .run(run_absent), .limit(g_absent),
    .expired(absent_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      set_q   <= '0;
      latch_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (present_done) begin
            latch_q <= code_i;
            set_q   <= '0;
            st_q    <= (SETTLE_CYC > 0) ? ST_SETTLE : ST_HELD;
          end
        end
        ST_SETTLE: begin
          if (set_q == SET_LAST) st_q <= ST_HELD;
          else                   set_q <= set_q + 1'b1;
        end
        ST_HELD: begin
          if (absent_done) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign std_o = (st_q == ST_HELD);
  assign q_o   = oe_i ? latch_q : {CODE_W{1'bz}};
endmodule

// File: rtl/dtmf_steer_chk.sv
module dtmf_steer_chk #(
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              est_i,
  input logic              oe_i,
  input logic              std_o,
  input logic [CODE_W-1:0] q_o,
  input logic [CODE_W-1:0] latch_q
);
  // R2: the latch does not move while the strobe stays up
  p_latch_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (std_o && $past(std_o)) |-> $stable(latch_q));

  // R3: data is settled before the strobe rises
  p_data_before_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(std_o) |-> $stable(latch_q));

  // R1: a latch update needs early steering present
  p_capture_needs_est_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(latch_q) |-> $past(est_i));

  // R4: strobe falls only while tone is absent
  p_release_needs_absence_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(std_o) |-> !$past(est_i));

  // R6: enabled bus shows the latch
  p_bus_drives_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    oe_i |-> (q_o == latch_q));
endmodule

bind dtmf_steer dtmf_steer_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .est_i(est_i), .oe_i(oe_i), .std_o(std_o),
  .q_o(q_o), .latch_q(latch_q)
);

// File: tb/tb_dtmf_steer.sv
module tb_dtmf_steer;
  localparam int N   = 3;
  localparam int SET = 2;
  localparam int PD  = 2;
  localparam int AD  = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        est = 1'b0;
  logic [3:0]  code = 4'h0;
  logic        cfg_wr = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [15:0] cfg_data = 16'h0;
  logic        oe = 1'b1;
  wire  [3:0]  q;
  wire         std;

  int n_chk = 0;
  int n_fail = 0;
  logic [3:0] last_code;
  logic done = 1'b0;

  always #5 clk = ~clk;

  dtmf_steer #(.TICK_CYC(N), .SETTLE_CYC(SET), .PRESENT_DEF(PD), .ABSENT_DEF(AD)) dut (
    .clk(clk), .rst_n(rst_n), .est_i(est), .code_i(code), .cfg_wr_i(cfg_wr),
    .cfg_sel_i(cfg_sel), .cfg_data_i(cfg_data), .oe_i(oe), .q_o(q), .std_o(std)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_guard(input logic sel, input int v);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_data = 16'(v);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // tone of exactly len high edges, then idle; expects no registration (R1)
  task automatic short_burst(input int gp, input int ga, input logic [3:0] c);
    est = 1'b1; code = c;
    for (int k = 1; k <= gp*N; k++) begin
      @(negedge clk);
      check("R1 short burst strobe", {3'b0, std}, 4'h0);
    end
    est = 1'b0;
    for (int k = 1; k <= gp*N + SET + 2; k++) begin
      @(negedge clk);
      check("R1 short burst strobe", {3'b0, std}, 4'h0);
    end
    check("R1 short burst latch", q, last_code);
  endtask

  // full digit: qualification, dropout, code change, release
  task automatic digit(input int gp, input int ga, input logic [3:0] c);
    est = 1'b1; code = c;
    for (int k = 1; k <= gp*N + SET + 2; k++) begin
      @(negedge clk);
      check("R3 strobe timing", {3'b0, std}, {3'b0, (k >= gp*N + SET + 1)});
      check("R1 latch update", q, (k >= gp*N + 1) ? c : last_code);
    end
    last_code = c;
    // dropout just under the absent guard (R4)
    est = 1'b0;
    for (int k = 1; k <= ga*N; k++) begin
      @(negedge clk);
      check("R4 dropout ignored", {3'b0, std}, 4'h1);
    end
    // tone resumes with another code: must not be captured (R2)
    est = 1'b1; code = ~c;
    for (int k = 1; k <= gp*N + SET + 3; k++) begin
      @(negedge clk);
      check("R2 held strobe", {3'b0, std}, 4'h1);
      check("R2 no recapture", q, c);
    end
    est = 1'b0;
    for (int k = 1; k <= ga*N + 2; k++) begin
      @(negedge clk);
      check("R4 release timing", {3'b0, std}, {3'b0, (k < ga*N + 1)});
    end
    check("R8 latch after release", q, c);
  endtask

  initial begin
    last_code = 4'h0;
    repeat (3) @(negedge clk);
    check("R7 reset strobe", {3'b0, std}, 4'h0);
    check("R7 reset latch", q, 4'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // defaults in effect (R7)
    short_burst(PD, AD, 4'h5);
    digit(PD, AD, 4'h5);
    // R8: after release, a fresh tone needs a full present guard again
    digit(PD, AD, 4'h9);
    // R5 sweep: present and absent guards set independently
    for (int gp = 1; gp <= 3; gp++) begin
      for (int ga = 1; ga <= 3; ga++) begin
        set_guard(1'b0, gp);
        set_guard(1'b1, ga);
        short_burst(gp, ga, 4'(gp*4 + ga));
        digit(gp, ga, 4'(gp*4 + ga));
      end
    end
    // R6: output enable
    set_guard(1'b0, 1);
    digit(1, AD, 4'hF);
    @(negedge clk);
    check("R6 enabled bus", q, 4'hF);
    oe = 1'b0;
    @(negedge clk);
    n_chk++;
    if (q === 4'hF) begin
      n_fail++;
      $display("FAIL R6 disabled bus: got %h expected zzzz", q);
    end
    oe = 1'b1;
    @(negedge clk);
    check("R6 re-enabled bus", q, 4'hF);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule